// File: doc/BRIEF.md
# I2C Register Target with Coherent Position Snapshot

This block is an I2C target that serves a small byte-addressed register file to an external controller. A write transaction loads the register pointer from its first data byte and writes every later byte at the pointer. A read transaction returns bytes from the pointer onward. After each data byte, in either direction, the pointer moves up by one. Seven configuration bytes are writable and are driven out to the rest of the chip. The remaining locations are read-only windows onto core state: a multi-byte turn counter, its CRC byte, the synchronization bits, a chip release identifier and an error status byte.

The counter, CRC and sync values change while the chip runs. A burst read must still see one consistent position. To give that, the block copies all of them into a shadow register when it accepts an address byte whose read/write bit is high. Every read byte is served from that shadow. Separate single-byte reads each take a fresh copy, so they can mix bytes from different positions. A configuration bit reserves position readout for another interface. While it is clear, the position window reads as zero and no copy is taken.

SCL and SDA are oversampled on the system clock. The block drives SDA only through an open-drain enable and never stretches SCL. The controller is therefore never held off, and no back-pressure path exists.

Top module: `pos_i2c_target`

## Requirements
- R1: After reset, `sda_oe` is low, every configuration byte is 0x00 and `pos_en` is low.
- R2: The target ACKs an address byte whose upper seven bits equal 0b1100001. For any other address it leaves SDA released (NACK) and ignores the bus until the next START.
- R3: Every data byte of a write transaction is ACKed. The first data byte loads the register pointer. Each later byte is written at the pointer, and the pointer then increments by one.
- R4: Locations 0x00 to 0x06 are writable configuration bytes. Byte n appears on `cfg_q[8n+7:8n]`, and `pos_en` follows bit 7 of location 0x05.
- R5: A read returns the byte at the pointer, most significant bit first, and the pointer increments after every byte. When the controller NACKs a byte, SDA stays released until the next START.
- R6: Read map: 0x07 to 0x0B return the counter with its most significant byte at 0x07. 0x0C returns the CRC byte. 0x0D returns the sync bits in bits 2:0, with upper bits zero. 0x0F returns `chip_rel` and 0x10 returns `err_status`. Location 0x0E and every location above 0x10 read as 0x00.
- R7: While `pos_en` is 1, accepting a read address copies the counter, CRC and sync inputs into a shadow register. That copy is the only thing that changes the shadow, and all position reads in the transaction come from it.
- R8: While `pos_en` is 0, locations 0x07 to 0x0D read as 0x00 and no copy is taken.
- R9: Writes to any location from 0x07 upward, including 0x0F, change no state other than the pointer.
- R10: A START or STOP at any bit position aborts the current byte. A START, repeated or not, begins a new address phase. A STOP returns the target to idle with SDA released.
- R11: `sda_oe` is high only during the target's own ACK bit or during a read data bit whose value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| live_count | input | CNT_BYTES*8 | Live turn counter from the core |
| live_crc | input | 8 | Live CRC byte of the counter |
| live_sync | input | SYNC_BITS | Live synchronization bits |
| chip_rel | input | 8 | Read-only chip release identifier |
| err_status | input | 8 | Error status byte from the monitors |
| cfg_q | output | NUM_CFG*8 | Configuration bytes, byte n at bits 8n+7:8n |
| pos_en | output | 1 | Position readout reserved for I2C |

## Verification
The main corner case is a change to the live counter in the middle of a burst. A design that read live values, or that re-latched on each byte, would return a torn position. The bench also reads single bytes in separate transactions and expects fresh values, which catches a design that never refreshes its shadow. Further tests write into the read-only range, 0x0F included, and abort a byte with a STOP or a repeated START in the middle. A register map that wrote through, or an engine that kept partial bits, would then corrupt later reads. Other tests read the position window with readout disabled and NACK the last read byte. A leaked value shows up in the first test, and a target still driving SDA shows up in the second.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } eng_state_t;

endpackage

// File: rtl/pit_line_sync.sv
module pit_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
      prev <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], line_i};
      prev <= pipe[STAGES-1];
    end
  end

  assign line_s = pipe[STAGES-1];
  assign rise   = line_s & ~prev;
  assign fall   = ~line_s & prev;
endmodule

// File: rtl/pit_byte_engine.sv
module pit_byte_engine
  import pit_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output eng_state_t state,
  output logic       start_evt,
  output logic       stop_evt,
  output logic       addr_rd_hit,
  output logic       wr_ptr_stb,
  output logic       wr_data_stb,
  output logic [7:0] wr_byte,
  output logic       rd_adv
);
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] txreg;
  logic       rw_q;
  logic       first_q;
  logic       nack_q;

  assign start_evt = scl & sda_fall;
  assign stop_evt  = scl & sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      txreg       <= '0;
      rw_q        <= 1'b0;
      first_q     <= 1'b0;
      nack_q      <= 1'b0;
      sda_oe      <= 1'b0;
      addr_rd_hit <= 1'b0;
      wr_ptr_stb  <= 1'b0;
      wr_data_stb <= 1'b0;
      wr_byte     <= '0;
      rd_adv      <= 1'b0;
    end else begin
      addr_rd_hit <= 1'b0;
      wr_ptr_stb  <= 1'b0;
      wr_data_stb <= 1'b0;
      rd_adv      <= 1'b0;
      if (start_evt) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda};
              bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall && bit_cnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) begin
                state       <= ST_ADDR_ACK;
                sda_oe      <= 1'b1;
                rw_q        <= shreg[0];
                addr_rd_hit <= shreg[0];
                first_q     <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                state  <= ST_RDATA;
                txreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                state  <= ST_WDATA;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda};
              bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall && bit_cnt == 4'd8) begin
              state   <= ST_WACK;
              sda_oe  <= 1'b1;
              wr_byte <= shreg;
              first_q <= 1'b0;
              if (first_q) wr_ptr_stb  <= 1'b1;
              else         wr_data_stb <= 1'b1;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              state   <= ST_WDATA;
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                state   <= ST_RACK;
                sda_oe  <= 1'b0;
                rd_adv  <= 1'b1;
                bit_cnt <= '0;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                txreg   <= {txreg[6:0], 1'b0};
                sda_oe  <= ~txreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) nack_q <= sda;
            if (scl_fall) begin
              if (nack_q) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end else begin
                state   <= ST_RDATA;
                txreg   <= rd_byte;
                sda_oe  <= ~rd_byte[7];
                bit_cnt <= '0;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pit_regs.sv
module pit_regs #(
  parameter int NUM_CFG   = 7,
  parameter int CNT_BYTES = 5,
  parameter int SYNC_BITS = 3,
  parameter int GATE_REG  = 5,
  localparam int CFG_W    = NUM_CFG * 8,
  localparam int CNT_W    = CNT_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ptr_stb,
  input  logic                 wr_data_stb,
  input  logic [7:0]           wr_byte,
  input  logic                 rd_adv,
  input  logic                 addr_rd_hit,
  input  logic [CNT_W-1:0]     live_count,
  input  logic [7:0]           live_crc,
  input  logic [SYNC_BITS-1:0] live_sync,
  input  logic [7:0]           chip_rel,
  input  logic [7:0]           err_status,
  output logic [7:0]           rd_byte,
  output logic [CFG_W-1:0]     cfg_q,
  output logic                 pos_en,
  output logic [CNT_W-1:0]     snap_count
);
  localparam int CNT_LO  = NUM_CFG;
  localparam int CRC_AD  = CNT_LO + CNT_BYTES;
  localparam int SYNC_AD = CRC_AD + 1;
  localparam int REL_AD  = SYNC_AD + 2;
  localparam int STAT_AD = REL_AD + 1;

  logic [7:0]           ptr;
  logic [CFG_W-1:0]     cfg_r;
  logic [7:0]           snap_crc;
  logic [SYNC_BITS-1:0] snap_sync;

  assign cfg_q  = cfg_r;
  assign pos_en = cfg_r[GATE_REG*8 + 7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      cfg_r <= '0;
    end else begin
      if (wr_ptr_stb) begin
        ptr <= wr_byte;
      end else if (wr_data_stb) begin
        for (int i = 0; i < NUM_CFG; i++) begin
          if (ptr == 8'(i)) cfg_r[i*8 +: 8] <= wr_byte;
        end
        ptr <= ptr + 8'd1;
      end else if (rd_adv) begin
        ptr <= ptr + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_count <= '0;
      snap_crc   <= '0;
      snap_sync  <= '0;
    end else if (addr_rd_hit && pos_en) begin
      snap_count <= live_count;
      snap_crc   <= live_crc;
      snap_sync  <= live_sync;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (ptr == 8'(i)) rd_byte = cfg_r[i*8 +: 8];
    end
    if (pos_en) begin
      for (int k = 0; k < CNT_BYTES; k++) begin
        if (ptr == 8'(CNT_LO + k)) rd_byte = snap_count[(CNT_BYTES-1-k)*8 +: 8];
      end
      if (ptr == 8'(CRC_AD))  rd_byte = snap_crc;
      if (ptr == 8'(SYNC_AD)) rd_byte = 8'(snap_sync);
    end
    if (ptr == 8'(REL_AD))  rd_byte = chip_rel;
    if (ptr == 8'(STAT_AD)) rd_byte = err_status;
  end
endmodule

// File: rtl/pos_i2c_target.sv
module pos_i2c_target
  import pit_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h61,
  parameter int         NUM_CFG     = 7,
  parameter int         CNT_BYTES   = 5,
  parameter int         SYNC_BITS   = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [CNT_BYTES*8-1:0] live_count,
  input  logic [7:0]             live_crc,
  input  logic [SYNC_BITS-1:0]   live_sync,
  input  logic [7:0]             chip_rel,
  input  logic [7:0]             err_status,
  output logic [NUM_CFG*8-1:0]   cfg_q,
  output logic                   pos_en
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_l, sync_l, rise_l, fall_l;
  assign raw_l = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    pit_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .line_i(raw_l[g]),
      .line_s(sync_l[g]), .rise(rise_l[g]), .fall(fall_l[g])
    );
  end

  eng_state_t             eng_state;
  logic                   start_evt, stop_evt, addr_rd_hit;
  logic                   wr_ptr_stb, wr_data_stb, rd_adv;
  logic [7:0]             wr_byte, rd_byte;
  logic [CNT_BYTES*8-1:0] snap_count;

  pit_byte_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .scl(sync_l[1]), .sda(sync_l[0]),
    .scl_rise(rise_l[1]), .scl_fall(fall_l[1]),
    .sda_rise(rise_l[0]), .sda_fall(fall_l[0]),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .state(eng_state),
    .start_evt(start_evt), .stop_evt(stop_evt), .addr_rd_hit(addr_rd_hit),
    .wr_ptr_stb(wr_ptr_stb), .wr_data_stb(wr_data_stb),
    .wr_byte(wr_byte), .rd_adv(rd_adv)
  );

  pit_regs #(.NUM_CFG(NUM_CFG), .CNT_BYTES(CNT_BYTES), .SYNC_BITS(SYNC_BITS)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_ptr_stb(wr_ptr_stb), .wr_data_stb(wr_data_stb), .wr_byte(wr_byte),
    .rd_adv(rd_adv), .addr_rd_hit(addr_rd_hit),
    .live_count(live_count), .live_crc(live_crc), .live_sync(live_sync),
    .chip_rel(chip_rel), .err_status(err_status),
    .rd_byte(rd_byte), .cfg_q(cfg_q), .pos_en(pos_en), .snap_count(snap_count)
  );
endmodule

// File: rtl/pos_i2c_target_chk.sv
module pos_i2c_target_chk
  import pit_pkg::*;
#(
  parameter int CFG_W = 56,
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input eng_state_t       state,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             addr_rd_hit,
  input logic             wr_ptr_stb,
  input logic             wr_data_stb,
  input logic             rd_adv,
  input logic             pos_en,
  input logic [CFG_W-1:0] cfg_q,
  input logic [CNT_W-1:0] snap_count
);
  AST_OE_DRIVE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == ST_ADDR_ACK || state == ST_WACK || state == ST_RDATA)); // R11

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !start_evt |=> (state == ST_IDLE && !sda_oe)); // R10

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> state == ST_ADDR); // R10

  AST_RD_HIT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_rd_hit |-> (state == ST_ADDR_ACK && sda_oe)); // R2

  AST_SNAP_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_rd_hit && pos_en) |=> $stable(snap_count)); // R7

  AST_SNAP_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_rd_hit && !pos_en) |=> $stable(snap_count)); // R8

  AST_CFG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_stb |=> $stable(cfg_q)); // R9

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ptr_stb, wr_data_stb, rd_adv, addr_rd_hit})); // R3
endmodule

bind pos_i2c_target pos_i2c_target_chk #(.CFG_W(NUM_CFG*8), .CNT_W(CNT_BYTES*8)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .state(eng_state),
  .start_evt(start_evt), .stop_evt(stop_evt), .addr_rd_hit(addr_rd_hit),
  .wr_ptr_stb(wr_ptr_stb), .wr_data_stb(wr_data_stb), .rd_adv(rd_adv),
  .pos_en(pos_en), .cfg_q(cfg_q), .snap_count(snap_count)
);

// File: tb/pos_i2c_target_tb_top.sv
module pos_i2c_target_tb_top;
  localparam int Q = 8;
  localparam logic [7:0] AW = 8'hC2;
  localparam logic [7:0] AR = 8'hC3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_drv = 1'b1;
  logic        sda_drv = 1'b1;
  logic        sda_oe;
  logic        sda_bus;
  logic [39:0] live_count = 40'h1122334455;
  logic [7:0]  live_crc = 8'h3C;
  logic [2:0]  live_sync = 3'b101;
  logic [7:0]  chip_rel = 8'h04;
  logic [7:0]  err_status = 8'h81;
  logic [55:0] cfg_q;
  logic        pos_en;

  int  n_cmp = 0;
  int  n_err = 0;
  bit  done = 0;
  logic [7:0] rbuf [16];

  always #2 clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  pos_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus), .sda_oe(sda_oe),
    .live_count(live_count), .live_crc(live_crc), .live_sync(live_sync),
    .chip_rel(chip_rel), .err_status(err_status), .cfg_q(cfg_q), .pos_en(pos_en)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b0; tick(Q/2);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic clock_bit(input logic drv, output logic smp);
    sda_drv = drv; tick(Q);
    scl_drv = 1'b1; tick(Q/2);
    smp = sda_bus; tick(Q/2);
    scl_drv = 1'b0; tick(Q/2);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(~give_ack, s);
  endtask

  task automatic read_regs(input string req, input logic [7:0] ptr, input int n);
    logic a;
    i2c_start();
    write_byte(AW, a); check({req, " addr-w ack"}, 64'(a), 64'd1);
    write_byte(ptr, a); check({req, " ptr ack"}, 64'(a), 64'd1);
    i2c_start();
    write_byte(AR, a); check({req, " addr-r ack"}, 64'(a), 64'd1);
    for (int i = 0; i < n; i++) read_byte(i != n-1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic write_regs(input string req, input logic [7:0] ptr, input logic [7:0] d [8], input int n);
    logic a;
    i2c_start();
    write_byte(AW, a); check({req, " addr-w ack"}, 64'(a), 64'd1);
    write_byte(ptr, a); check({req, " ptr ack"}, 64'(a), 64'd1);
    for (int i = 0; i < n; i++) begin
      write_byte(d[i], a);
      check({req, " data ack"}, 64'(a), 64'd1);
    end
    i2c_stop();
  endtask

  task automatic t_reset();
    check("R1 sda_oe after reset", 64'(sda_oe), 64'd0);
    check("R1 cfg_q after reset", 64'(cfg_q), 64'd0);
    check("R1 pos_en after reset", 64'(pos_en), 64'd0);
  endtask

  task automatic t_addr_nack();
    logic a;
    i2c_start();
    write_byte(8'hC4, a);
    check("R2 foreign address nack", 64'(a), 64'd0);
    write_byte(8'h00, a);
    check("R2 bus ignored after nack", 64'(a), 64'd0);
    i2c_stop();
  endtask

  task automatic t_gated_read();
    read_regs("R8 gated", 8'h07, 10);
    for (int i = 0; i < 7; i++) check("R8 gated position byte zero", 64'(rbuf[i]), 64'd0);
    check("R6 reserved 0x0E zero", 64'(rbuf[7]), 64'd0);
    check("R6 chip release", 64'(rbuf[8]), 64'(chip_rel));
    check("R6 error status", 64'(rbuf[9]), 64'(err_status));
  endtask

  task automatic t_cfg_write();
    logic [7:0] d [8];
    d = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'h85, 8'hA6, 8'h00};
    write_regs("R3 cfg write", 8'h00, d, 7);
    check("R4 cfg_q image", 64'(cfg_q), 64'h00A685A4A3A2A1A0);
    check("R4 pos_en from 0x05 bit7", 64'(pos_en), 64'd1);
  endtask

  task automatic t_cfg_readback();
    read_regs("R5 readback", 8'h02, 3);
    check("R5 read 0x02", 64'(rbuf[0]), 64'hA2);
    check("R5 read 0x03 autoinc", 64'(rbuf[1]), 64'hA3);
    check("R5 read 0x04 autoinc", 64'(rbuf[2]), 64'hA4);
    tick(4 * Q);
    check("R5 sda released after nack", 64'(sda_oe), 64'd0);
  endtask

  task automatic t_rom_write();
    logic [7:0] d [8];
    d = '{8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h00, 8'h00, 8'h00};
    write_regs("R9 ro write", 8'h0C, d, 5);
    check("R9 cfg untouched", 64'(cfg_q), 64'h00A685A4A3A2A1A0);
    read_regs("R9 ro readback", 8'h0F, 2);
    check("R9 chip release kept", 64'(rbuf[0]), 64'(chip_rel));
    check("R9 status kept", 64'(rbuf[1]), 64'(err_status));
  endtask

  task automatic t_snapshot_burst();
    logic a;
    live_count = 40'hC1C2C3C4C5; live_crc = 8'h77; live_sync = 3'b101;
    i2c_start();
    write_byte(AW, a); check("R7 burst addr-w ack", 64'(a), 64'd1);
    write_byte(8'h07, a); check("R7 burst ptr ack", 64'(a), 64'd1);
    i2c_start();
    write_byte(AR, a); check("R7 burst addr-r ack", 64'(a), 64'd1);
    read_byte(1'b1, rbuf[0]);
    live_count = 40'hD1D2D3D4D5; live_crc = 8'h11; live_sync = 3'b010;
    for (int i = 1; i < 7; i++) read_byte(i != 6, rbuf[i]);
    i2c_stop();
    check("R7 burst byte 0x07", 64'(rbuf[0]), 64'hC1);
    check("R7 burst byte 0x08", 64'(rbuf[1]), 64'hC2);
    check("R7 burst byte 0x09", 64'(rbuf[2]), 64'hC3);
    check("R7 burst byte 0x0A", 64'(rbuf[3]), 64'hC4);
    check("R6 counter lsb at 0x0B", 64'(rbuf[4]), 64'hC5);
    check("R6 crc at 0x0C", 64'(rbuf[5]), 64'h77);
    check("R6 sync at 0x0D", 64'(rbuf[6]), 64'h05);
  endtask

  task automatic t_single_reads();
    read_regs("R7 single", 8'h07, 1);
    check("R7 single 0x07 fresh", 64'(rbuf[0]), 64'hD1);
    live_count = 40'hE1E2E3E4E5;
    read_regs("R7 single", 8'h08, 1);
    check("R7 single 0x08 new snapshot", 64'(rbuf[0]), 64'hE2);
  endtask

  task automatic t_abort();
    logic a, s;
    i2c_start();
    write_byte(AW, a); check("R10 abort addr ack", 64'(a), 64'd1);
    clock_bit(1'b0, s); clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b1, s);
    i2c_stop();
    check("R10 released after stop", 64'(sda_oe), 64'd0);
    i2c_start();
    clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b1, s);
    read_regs("R10 after repeated start", 8'h06, 1);
    check("R10 read after aborts", 64'(rbuf[0]), 64'hA6);
    check("R10 cfg intact", 64'(cfg_q), 64'h00A685A4A3A2A1A0);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_addr_nack();
    t_gated_read();
    t_cfg_write();
    t_cfg_readback();
    t_rom_write();
    t_snapshot_burst();
    t_single_reads();
    t_abort();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule